// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frame bytes from a simple byte stream (valid, data, last) and scatters them into a ring of fixed-size receive buffers in system memory. Each buffer is described by a two-word descriptor held in a small internal memory: an address word that gives the buffer base and carries two flags in its low bits, and a status word that the block fills in when it finishes with the buffer. Software reaches the descriptors through a host read/write port. It uses that port to load buffer addresses at start-up and to give buffers back after it has consumed them.

Frames longer than one buffer continue into the next descriptor. The first buffer of a frame is tagged as the frame start. Only the descriptor that ends the frame carries the end flag and the total length. After the descriptor at the end of the ring, or after any descriptor whose wrap flag is set, the next one used is entry 0. If the block reaches a descriptor that software has not yet returned, it drops the remaining bytes of that frame and latches a buffer-not-available flag. A single-cycle pulse reports each frame that completes.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every descriptor word reads 0, and `bna` and `rx_done` are 0.
- R2: A host write updates the word chosen by `host_addr` (bits 3:1 = descriptor index, bit 0 = 0 for the address word, 1 for the status word). `host_rdata` returns the selected word combinationally.
- R3: Each stored byte appears on the buffer write port one cycle after it is accepted. Its address is the descriptor's address word with bits 2:0 cleared, plus the byte's offset within the 128-byte buffer.
- R4: A frame of 1 to 128 bytes uses one descriptor. The block sets address bit 0 (owned) and writes status = bit 15 (end) | bit 14 (start) | length in bits 11:0. All other status bits are 0.
- R5: After 128 bytes the frame continues at offset 0 of the next descriptor. Each filled buffer is marked owned. The first descriptor of the frame gets status bit 14 only, middle descriptors get status 0, and the last gets bit 15 plus the total frame length.
- R6: The descriptor that follows entry 7, or any entry whose address bit 1 (wrap) is set, is entry 0. Descriptors skipped by a wrap are left untouched.
- R7: `rx_done` is high for exactly one cycle: the cycle after the last byte of a frame that was fully stored. It does not go high for a frame that was dropped.
- R8: If a buffer is about to start and its descriptor is already owned, that byte and the rest of the frame are discarded: no buffer writes and no descriptor change. `bna` is set and stays set until reset. The next frame tries the same descriptor again.
- R9: Marking a descriptor owned keeps all other address-word bits, including the wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Descriptor index (bits 3:1) and word select (bit 0) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected descriptor word |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| buf_we | output | 1 | Buffer memory write strobe |
| buf_addr | output | 32 | Buffer memory byte address |
| buf_data | output | 8 | Buffer memory write data |
| rx_done | output | 1 | One-cycle frame-complete pulse |
| bna | output | 1 | Sticky buffer-not-available flag |

## Verification
The bench targets the buffer seams. It sends a frame of exactly 128 bytes, which must not spill into a second descriptor, and frames of 300 and 400 bytes that run across several buffers. A design that got these wrong would tag the wrong descriptor with the start or end flag, or would show a non-zero length before the last buffer. Wrapping is exercised both at the end of the ring and through a mid-ring wrap flag; an off-by-one in the next-index logic would write into entry 3 or lose the wrap bit when it sets ownership. Ownership collisions are tested at the very first byte of a frame and midway through one, then a returned buffer is used to recover. A design that mishandled these would write dropped bytes, pulse `rx_done`, or clear the flag.

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int NUM_DESC  = 8,
  parameter int BUF_BYTES = 128,
  parameter int AW        = 32,
  parameter int LEN_W     = 12,
  parameter int ALIGN     = 3,
  parameter int SOF_BIT   = 14,
  parameter int EOF_BIT   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [3:0]    host_addr,
  input  logic [AW-1:0] host_wdata,
  output logic [AW-1:0] host_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic          rx_done,
  output logic          bna
);
  localparam int IDX_W = $clog2(NUM_DESC);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BUF_BYTES - 1);

  logic [AW-1:0]    addr_w [NUM_DESC];
  logic [AW-1:0]    stat_w [NUM_DESC];
  logic [IDX_W-1:0] cur;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] flen;
  logic             first, drop;

  wire [IDX_W-1:0] hidx = host_addr[IDX_W:1];
  assign host_rdata = host_addr[0] ? stat_w[hidx] : addr_w[hidx];

  wire              take    = in_valid && !drop;
  wire              block   = take && off == '0 && addr_w[cur][0];
  wire              store   = take && !block;
  wire              buf_end = store && (off == LAST_OFF || in_last);
  wire [LEN_W-1:0]  new_len = flen + LEN_W'(1);
  wire [IDX_W-1:0]  nxt     = (addr_w[cur][1] || cur == LAST_IDX) ? '0 : cur + IDX_W'(1);

  logic [AW-1:0] st_val;
  always_comb begin
    st_val = '0;
    if (in_last) st_val[LEN_W-1:0] = new_len;
    st_val[SOF_BIT] = first;
    st_val[EOF_BIT] = in_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        addr_w[i] <= '0;
        stat_w[i] <= '0;
      end
    end else begin
      if (host_we) begin
        if (host_addr[0]) stat_w[hidx] <= host_wdata;
        else              addr_w[hidx] <= host_wdata;
      end
      if (buf_end) begin
        addr_w[cur] <= addr_w[cur] | AW'(1);
        stat_w[cur] <= st_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      off      <= '0;
      flen     <= '0;
      first    <= 1'b1;
      drop     <= 1'b0;
      bna      <= 1'b0;
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      rx_done  <= 1'b0;
    end else begin
      buf_we  <= store;
      rx_done <= store && in_last;
      if (store) begin
        buf_addr <= {addr_w[cur][AW-1:ALIGN], ALIGN'(0)} + AW'(off);
        buf_data <= in_data;
        off      <= off + OFF_W'(1);
        flen     <= in_last ? '0 : new_len;
      end
      if (buf_end) begin
        cur   <= nxt;
        off   <= '0;
        first <= in_last;
      end
      if (block) begin
        bna   <= 1'b1;
        drop  <= !in_last;
        flen  <= '0;
        first <= 1'b1;
      end
      if (drop && in_valid && in_last) drop <= 1'b0;
    end
  end
endmodule

module rx_desc_ring_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_last,
  input logic buf_we,
  input logic rx_done,
  input logic bna
);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(in_valid && in_last));
  a_r7_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> buf_we);
  a_r3_write_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(in_valid));
  a_r8_bna_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bna) |-> bna);
  a_r8_no_write_on_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bna) |-> !buf_we);
endmodule

bind rx_desc_ring rx_desc_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .buf_we(buf_we), .rx_done(rx_done), .bna(bna)
);

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb;
  logic        clk = 1'b0;
  logic        rst_n, host_we, in_valid, in_last;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata, host_rdata, buf_addr;
  logic [7:0]  in_data, buf_data;
  logic        buf_we, rx_done, bna;

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [39:0] exp_q[$];
  logic [31:0] base_tab[4];

  always #4 clk = ~clk;

  rx_desc_ring u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .rx_done(rx_done), .bna(bna)
  );

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) n_done++;
      if (buf_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 R8 unexpected write", {buf_addr, buf_data}, '0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({buf_addr, buf_data} == e, "R3 buffer write", {buf_addr, buf_data}, e);
        end
      end
    end
  end

  task automatic wr(input int idx, input int w, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'(idx * 2 + w); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic chk_desc(input int idx, input logic [31:0] ea, input logic [31:0] es, input string req);
    @(negedge clk);
    host_addr = 4'(idx * 2); #1;
    chk(host_rdata == ea, req, 40'(host_rdata), 40'(ea));
    host_addr = 4'(idx * 2 + 1); #1;
    chk(host_rdata == es, req, 40'(host_rdata), 40'(es));
  endtask

  task automatic send_frame(input int len, input int seed, input int keep);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed + i * 7);
      in_last  = (i == len - 1);
      if (i < keep) exp_q.push_back({base_tab[i / 128] + 32'(i % 128), in_data});
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(rx_done == (keep == len), "R7 done pulse timing", 40'(rx_done), 40'(keep == len));
    @(negedge clk);
    chk(rx_done == 1'b0, "R7 done single cycle", 40'(rx_done), 40'(0));
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 R8 writes outstanding", 40'(exp_q.size()), 40'(0));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) chk_desc(i, 32'h0, 32'h0, "R1 reset descriptor");
    chk(bna == 1'b0 && rx_done == 1'b0, "R1 reset flags", 40'({bna, rx_done}), 40'(0));

    // R2 host access
    wr(5, 1, 32'h1234_5678);
    chk_desc(5, 32'h0, 32'h1234_5678, "R2 host write/read");
    for (int i = 0; i < 8; i++) begin
      wr(i, 0, 32'h1000 + 32'(i * 128));
      wr(i, 1, 32'h0);
    end

    // R4 short frame
    base_tab[0] = 32'h1000;
    send_frame(10, 3, 10);
    chk_desc(0, 32'h1001, 32'h0000_C00A, "R4 single buffer");
    chk_desc(1, 32'h1080, 32'h0, "R4 next untouched");

    // R5 three buffers
    base_tab[0] = 32'h1080; base_tab[1] = 32'h1100; base_tab[2] = 32'h1180;
    send_frame(300, 11, 300);
    chk_desc(1, 32'h1081, 32'h0000_4000, "R5 first buffer");
    chk_desc(2, 32'h1101, 32'h0, "R5 middle buffer");
    chk_desc(3, 32'h1181, 32'h0000_812C, "R5 last buffer");
    for (int i = 0; i < 4; i++) wr(i, 0, 32'h1000 + 32'(i * 128));

    // R4 exact buffer size
    base_tab[0] = 32'h1200;
    send_frame(128, 40, 128);
    chk_desc(4, 32'h1201, 32'h0000_C080, "R4 exactly 128 bytes");
    chk_desc(5, 32'h1280, 32'h0, "R4 no spill at 128");

    // R6 wrap at ring end
    base_tab[0] = 32'h1280; base_tab[1] = 32'h1300; base_tab[2] = 32'h1380; base_tab[3] = 32'h1000;
    send_frame(400, 77, 400);
    chk_desc(5, 32'h1281, 32'h0000_4000, "R6 span start");
    chk_desc(7, 32'h1381, 32'h0, "R6 last entry");
    chk_desc(0, 32'h1001, 32'h0000_8190, "R6 wrapped to entry 0");

    for (int i = 0; i < 8; i++) begin
      wr(i, 0, 32'h1000 + 32'(i * 128));
      wr(i, 1, 32'h0);
    end
    wr(2, 0, 32'h1102);

    // R6 R9 wrap flag mid ring
    base_tab[0] = 32'h1080; base_tab[1] = 32'h1100;
    send_frame(200, 5, 200);
    chk_desc(1, 32'h1081, 32'h0000_4000, "R5 start of 200 byte frame");
    chk_desc(2, 32'h1103, 32'h0000_80C8, "R9 wrap flag kept");
    base_tab[0] = 32'h1000;
    send_frame(5, 99, 5);
    chk_desc(0, 32'h1001, 32'h0000_C005, "R6 wrap flag to entry 0");
    chk_desc(3, 32'h1180, 32'h0, "R6 skipped entry untouched");
    chk(bna == 1'b0, "R8 no flag yet", 40'(bna), 40'(0));

    // R8 owned at frame start
    send_frame(20, 1, 0);
    chk(bna == 1'b1, "R8 flag set", 40'(bna), 40'(1));
    chk_desc(1, 32'h1081, 32'h0000_4000, "R8 descriptor unchanged");

    // R8 owned mid frame
    wr(1, 0, 32'h1080); wr(1, 1, 32'h0);
    base_tab[0] = 32'h1080;
    send_frame(150, 17, 128);
    chk_desc(1, 32'h1081, 32'h0000_4000, "R8 partial buffer");
    chk_desc(2, 32'h1103, 32'h0000_80C8, "R8 blocked descriptor unchanged");

    // R8 recovery on same descriptor, flag sticky
    wr(2, 0, 32'h1102);
    base_tab[0] = 32'h1100;
    send_frame(3, 60, 3);
    chk_desc(2, 32'h1103, 32'h0000_C003, "R8 retry same descriptor");
    chk(bna == 1'b1, "R8 flag sticky", 40'(bna), 40'(1));
    chk(n_done == 7, "R7 completed frame count", 40'(n_done), 40'(7));

    finish_run();
  end
endmodule